// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, day of week, day of month, month, two-digit year and a century flag. Eight byte-wide registers sit at consecutive offsets behind a synchronous write port with a combinational read path. The time advances once for every `sec_tick` pulse from an external one-second prescaler. Carries run through the whole calendar, including month lengths and leap Februaries. The same bytes also hold a few control bits: oscillator stop, frequency-test enable, century enable, battery-low enable and a read-only battery-low flag.

Software reaches the time through a small access machine with four states. `ACC_LIVE` gives plain operation. `ACC_SNAP` is read-freeze: a control write with the read bit set and the write bit clear enters it, and it serves reads from a frozen copy. `ACC_STAGE` is write-staging: a control write with the write bit set enters it from `ACC_LIVE` or `ACC_SNAP`. In this state the counters keep running while byte writes collect in staging registers. A control write with the write bit clear moves `ACC_STAGE` to `ACC_COMMIT`. That state lasts one cycle, loads only the staged bytes into the counters, and always returns to `ACC_LIVE`. A control write with both bits clear moves `ACC_SNAP` back to `ACC_LIVE`. The write bit wins when both bits are set.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset, the bytes at offsets 0 to 7 read 00, 00, 00, 00, 01, 01, 01, 00, and `ftest_en` is 0.
- R2: Offset 0 is control {W, R, S, cal[4:0]}. Offset 1 is {stop, sec[6:0]}. Offset 2 is {0, min[6:0]}. Offset 3 is {00, hour[5:0]}. Offset 4 is {0, ftest, cen_en, century, 0, dow[2:0]}. Offset 5 is {batt_en, batt_low, date[5:0]}. Offset 6 is {000, month[4:0]}. Offset 7 is year[7:0]. Bits shown as zero here always read 0.
- R3: Seconds and minutes count 00 to 59 and hours count 00 to 23 in BCD. Each one wraps to 00 and carries into the next field.
- R4: The date wraps to 01 after the last day of the month and the month then increments. April, June, September and November have 30 days, and the other months except February have 31. February has 29 days when the year value is a multiple of 4 and 28 otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R5: The day of week counts 1 to 7, advances on every date change, and wraps from 7 to 1.
- R6: With cen_en set, the century bit inverts when the year wraps from 99 to 00. With cen_en clear, the century bit does not change by counting.
- R7: While the stop bit is 1, `sec_tick` does not advance the time.
- R8: While W is 0, writes to the time fields (the seconds, minutes, hour, century/day-of-week, date, month and year digits) have no effect. A control write with W=1 starts staging. During staging the counters still run and W reads back as 1. The control write that clears W loads only the staged bytes, and the loaded values are visible one cycle after that write.
- R9: A control write with R=1 and W=0 freezes the values read at offsets 1 to 7 as they stood at that write, and R reads back as 1. A control write with R=0 and W=0 returns reads to the live values.
- R10: Stop, ftest, cen_en, batt_en and the S/cal bits take effect on any write, whatever W is. `ftest_en` equals ftest AND NOT stop.
- R11: The battery-low bit shows the `batt_low` input one clock after it is sampled, and writes to that bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| batt_low | input | 1 | Battery-low indication from the supply monitor |
| ftest_en | output | 1 | Frequency-test output enable |

## Verification
The counter assertions assume that every value loaded through staging is valid BCD inside its field's range. They also assume that no `sec_tick` arrives in the one-cycle commit state. The stimulus stages only legal values, and it sends ticks only after the commit cycle has passed. The single exception is the fixed-zero readback at the very end, after which no further ticks are sent. The access-machine properties assume a control write is a single-cycle `wr_en` pulse. The bench drives every write that way.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
package bcd_cal_pkg;

    localparam int REG_W      = 8;
    localparam int NUM_REGS   = 8;
    localparam int ADDR_W     = $clog2(NUM_REGS);
    localparam int NUM_FIELDS = 7;

    // register offsets (software-visible map)
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_SEC  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_MIN  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_HR   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_CDAY = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_DATE = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MON  = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_YEAR = 3'd7;

    // counter field indices
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HR   = 2;
    localparam int F_DATE = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;
    localparam int F_DOW  = 6;

    typedef enum logic [1:0] {
        ACC_LIVE   = 2'd0,
        ACC_SNAP   = 2'd1,
        ACC_STAGE  = 2'd2,
        ACC_COMMIT = 2'd3
    } acc_state_t;

    function automatic logic [REG_W-1:0] bcd_next(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [REG_W-1:0] field_min(input int f);
        logic [REG_W-1:0] r;
        case (f)
            F_DATE, F_MON, F_DOW: r = 8'h01;
            default:              r = 8'h00;
        endcase
        return r;
    endfunction

    function automatic logic [REG_W-1:0] field_cap(input int f);
        logic [REG_W-1:0] r;
        case (f)
            F_SEC, F_MIN: r = 8'h59;
            F_HR:         r = 8'h23;
            F_DATE:       r = 8'h31;
            F_MON:        r = 8'h12;
            F_YEAR:       r = 8'h99;
            default:      r = 8'h07;
        endcase
        return r;
    endfunction

    function automatic logic [REG_W-1:0] field_mask(input int f);
        logic [REG_W-1:0] r;
        case (f)
            F_SEC, F_MIN: r = 8'h7F;
            F_HR, F_DATE: r = 8'h3F;
            F_MON:        r = 8'h1F;
            F_YEAR:       r = 8'hFF;
            default:      r = 8'h07;
        endcase
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] field_ofs(input int f);
        logic [ADDR_W-1:0] r;
        case (f)
            F_SEC:   r = OFS_SEC;
            F_MIN:   r = OFS_MIN;
            F_HR:    r = OFS_HR;
            F_DATE:  r = OFS_DATE;
            F_MON:   r = OFS_MON;
            F_YEAR:  r = OFS_YEAR;
            default: r = OFS_CDAY;
        endcase
        return r;
    endfunction

    // year value (BCD) divisible by four
    function automatic logic leap_bcd(input logic [REG_W-1:0] y);
        logic [3:0] u;
        u = y[3:0];
        if (!y[4]) return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
        else       return (u == 4'd2) || (u == 4'd6);
    endfunction

    function automatic logic [REG_W-1:0] month_len(input logic [REG_W-1:0] m,
                                                   input logic [REG_W-1:0] y);
        logic [REG_W-1:0] r;
        case (m)
            8'h02:                      r = leap_bcd(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcd_field_ctr.sv
`timescale 1ns/1ps
module bcd_field_ctr
    import bcd_cal_pkg::*;
#(
    parameter logic [REG_W-1:0] MIN_VAL = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic [REG_W-1:0] cap,
    output logic [REG_W-1:0] val,
    output logic             wrap
);

    logic [REG_W-1:0] cnt_q;
    logic             at_cap;

    assign at_cap = (cnt_q >= cap);
    assign wrap   = inc && at_cap;
    assign val    = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= MIN_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (inc) begin
            cnt_q <= at_cap ? MIN_VAL : bcd_next(cnt_q);
        end
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(cnt_q));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && cnt_q == cap) |=> (cnt_q == MIN_VAL));

endmodule

// File: rtl/bcd_cal_access.sv
`timescale 1ns/1ps
module bcd_cal_access
    import bcd_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       want_write,
    input  logic       want_read,
    output acc_state_t state_q,
    output logic       stage_open,
    output logic       stage_start,
    output logic       commit,
    output logic       snap_take,
    output logic       snap_active
);

    acc_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_LIVE: begin
                if (ctrl_we) begin
                    if (want_write)     state_d = ACC_STAGE;
                    else if (want_read) state_d = ACC_SNAP;
                end
            end
            ACC_SNAP: begin
                if (ctrl_we) begin
                    if (want_write)      state_d = ACC_STAGE;
                    else if (!want_read) state_d = ACC_LIVE;
                end
            end
            ACC_STAGE: begin
                if (ctrl_we && !want_write) state_d = ACC_COMMIT;
            end
            ACC_COMMIT: state_d = ACC_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_LIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        stage_open  = 1'b0;
        stage_start = 1'b0;
        commit      = 1'b0;
        snap_take   = 1'b0;
        snap_active = 1'b0;
        unique case (state_q)
            ACC_LIVE: begin
                stage_start = ctrl_we && want_write;
                snap_take   = ctrl_we && !want_write && want_read;
            end
            ACC_SNAP: begin
                snap_active = 1'b1;
                stage_start = ctrl_we && want_write;
            end
            ACC_STAGE:  stage_open = 1'b1;
            ACC_COMMIT: commit     = 1'b1;
        endcase
    end

    // R8
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_COMMIT) |=> (state_q == ACC_LIVE));

    // R8
    stage_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_STAGE && ctrl_we && !want_write) |=> (state_q == ACC_COMMIT));

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_SNAP && !ctrl_we) |=> (state_q == ACC_SNAP));

endmodule

// File: rtl/bcd_calendar_core.sv
`timescale 1ns/1ps
module bcd_calendar_core
    import bcd_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              batt_low,
    output logic              ftest_en
);

    acc_state_t acc_state;
    logic       stage_open, stage_start, commit, snap_take, snap_active;
    logic       ctrl_we;

    logic       stop_q, ftest_q, cen_en_q, cent_q, batt_en_q, bl_q;
    logic [5:0] ctrl_lo_q;

    logic [REG_W-1:0]    stage_q [NUM_REGS];
    logic [NUM_REGS-1:0] dirty_q;
    logic [REG_W-1:0]    snap_q  [NUM_REGS];
    logic [REG_W-1:0]    img     [NUM_REGS];

    logic [REG_W-1:0]      fld_val [NUM_FIELDS];
    logic [REG_W-1:0]      fld_cap [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] fld_inc, fld_load, fld_wrap;

    assign ctrl_we = wr_en && (addr == OFS_CTRL);

    bcd_cal_access u_access (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .want_write  (wdata[7]),
        .want_read   (wdata[6]),
        .state_q     (acc_state),
        .stage_open  (stage_open),
        .stage_start (stage_start),
        .commit      (commit),
        .snap_take   (snap_take),
        .snap_active (snap_active)
    );

    // carry chain and per-field limits
    always_comb begin
        for (int f = 0; f < NUM_FIELDS; f++) begin
            fld_cap[f]  = field_cap(f);
            fld_load[f] = commit && dirty_q[field_ofs(f)];
        end
        fld_cap[F_DATE] = month_len(fld_val[F_MON], fld_val[F_YEAR]);
        fld_inc[F_SEC]  = sec_tick && !stop_q;
        fld_inc[F_MIN]  = fld_wrap[F_SEC];
        fld_inc[F_HR]   = fld_wrap[F_MIN];
        fld_inc[F_DATE] = fld_wrap[F_HR];
        fld_inc[F_MON]  = fld_wrap[F_DATE];
        fld_inc[F_YEAR] = fld_wrap[F_MON];
        fld_inc[F_DOW]  = fld_wrap[F_HR];
    end

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
        bcd_field_ctr #(
            .MIN_VAL (field_min(f))
        ) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (fld_inc[f]),
            .load     (fld_load[f]),
            .load_val (stage_q[field_ofs(f)] & field_mask(f)),
            .cap      (fld_cap[f]),
            .val      (fld_val[f]),
            .wrap     (fld_wrap[f])
        );
    end

    // control bits written directly, whatever the access state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q    <= 1'b0;
            ftest_q   <= 1'b0;
            cen_en_q  <= 1'b0;
            batt_en_q <= 1'b0;
            ctrl_lo_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_SEC)  stop_q <= wdata[7];
            if (addr == OFS_CDAY) begin
                ftest_q  <= wdata[6];
                cen_en_q <= wdata[5];
            end
            if (addr == OFS_DATE) batt_en_q <= wdata[7];
            if (addr == OFS_CTRL) ctrl_lo_q <= wdata[5:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bl_q <= 1'b0;
        else        bl_q <= batt_low;
    end

    // century flag: staged load wins over roll-over toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cent_q <= 1'b0;
        end else if (commit && dirty_q[OFS_CDAY]) begin
            cent_q <= stage_q[OFS_CDAY][4];
        end else if (fld_wrap[F_YEAR] && cen_en_q) begin
            cent_q <= ~cent_q;
        end
    end

    // staging buffer with per-byte dirty marks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '0;
            for (int i = 0; i < NUM_REGS; i++) stage_q[i] <= '0;
        end else if (stage_start) begin
            dirty_q <= '0;
        end else if (stage_open && wr_en && addr != OFS_CTRL) begin
            stage_q[addr] <= wdata;
            dirty_q[addr] <= 1'b1;
        end
    end

    // read image
    always_comb begin
        img[OFS_CTRL] = {acc_state == ACC_STAGE, acc_state == ACC_SNAP, ctrl_lo_q};
        img[OFS_SEC]  = {stop_q, 7'b0} | (fld_val[F_SEC] & field_mask(F_SEC));
        img[OFS_MIN]  = fld_val[F_MIN] & field_mask(F_MIN);
        img[OFS_HR]   = fld_val[F_HR] & field_mask(F_HR);
        img[OFS_CDAY] = {1'b0, ftest_q, cen_en_q, cent_q, 4'b0}
                      | (fld_val[F_DOW] & field_mask(F_DOW));
        img[OFS_DATE] = {batt_en_q, bl_q, 6'b0} | (fld_val[F_DATE] & field_mask(F_DATE));
        img[OFS_MON]  = fld_val[F_MON] & field_mask(F_MON);
        img[OFS_YEAR] = fld_val[F_YEAR];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) snap_q[i] <= '0;
        end else if (snap_take) begin
            for (int i = 0; i < NUM_REGS; i++) snap_q[i] <= img[i];
        end
    end

    always_comb begin
        if (snap_active && addr != OFS_CTRL) rdata = snap_q[addr];
        else                                 rdata = img[addr];
    end

    assign ftest_en = ftest_q && !stop_q;

    // R7
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !commit) |=> $stable(fld_val[F_SEC]));

    // R6
    century_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_en_q && !(commit && dirty_q[OFS_CDAY])) |=> $stable(cent_q));

endmodule

// File: tb/tb_bcd_calendar_core.sv
`timescale 1ns/1ps
module tb_bcd_calendar_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       batt_low = 1'b0;
    logic       ftest_en;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_calendar_core dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .batt_low (batt_low),
        .ftest_en (ftest_en)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic expect_reg(input string req, input string what,
                              input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, what, v, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick1;
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic commit_stage;
        wr(3'd0, 8'h00);
        @(negedge clk);
    endtask

    task automatic set_time(input int h, input int m, input int s);
        wr(3'd0, 8'h80);
        wr(3'd3, bcd(h));
        wr(3'd2, bcd(m));
        wr(3'd1, bcd(s));
        commit_stage();
    endtask

    // calendar model
    int md, mm, yy, dw, cb, ceb;

    task automatic model_next_day;
        dw = (dw == 7) ? 1 : dw + 1;
        if (md == dim(mm, yy)) begin
            md = 1;
            if (mm == 12) begin
                mm = 1;
                if (yy == 99) begin
                    yy = 0;
                    if (ceb != 0) cb = cb ^ 1;
                end else begin
                    yy = yy + 1;
                end
            end else begin
                mm = mm + 1;
            end
        end else begin
            md = md + 1;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset image
        expect_reg("R1", "ctrl", 3'd0, 8'h00);
        expect_reg("R1", "sec", 3'd1, 8'h00);
        expect_reg("R1", "min", 3'd2, 8'h00);
        expect_reg("R1", "hour", 3'd3, 8'h00);
        expect_reg("R1", "cday", 3'd4, 8'h01);
        expect_reg("R1", "date", 3'd5, 8'h01);
        expect_reg("R1", "month", 3'd6, 8'h01);
        expect_reg("R1", "year", 3'd7, 8'h00);
        chk("R1", "ftest_en", {7'b0, ftest_en}, 8'h00);

        // R3 full day of seconds
        for (int t = 1; t <= 86400; t++) begin
            int tt;
            tt = t % 86400;
            tick1();
            expect_reg("R3", "sec", 3'd1, bcd(tt % 60));
            expect_reg("R3", "min", 3'd2, bcd((tt / 60) % 60));
            expect_reg("R3", "hour", 3'd3, bcd(tt / 3600));
        end
        expect_reg("R4", "date after day", 3'd5, 8'h02);
        expect_reg("R5", "dow after day", 3'd4, 8'h02);

        // R4 R5 R6 calendar sweep over four years across the century
        md = 1; mm = 1; yy = 98; dw = 1; cb = 0; ceb = 1;
        wr(3'd0, 8'h80);
        wr(3'd7, bcd(yy));
        wr(3'd6, 8'h01);
        wr(3'd5, 8'h01);
        wr(3'd4, 8'h21);
        wr(3'd3, 8'h23);
        wr(3'd2, 8'h59);
        wr(3'd1, 8'h59);
        commit_stage();
        for (int d = 0; d < 1461; d++) begin
            tick1();
            model_next_day();
            expect_reg("R4", "date", 3'd5, bcd(md));
            expect_reg("R4", "month", 3'd6, bcd(mm));
            expect_reg("R4", "year", 3'd7, bcd(yy));
            expect_reg("R6", "cday", 3'd4, 8'h20 | 8'(cb << 4) | 8'(dw));
            set_time(23, 59, 59);
        end

        // R4 February end for every year value
        for (int y = 0; y < 100; y++) begin
            wr(3'd0, 8'h80);
            wr(3'd7, bcd(y));
            wr(3'd6, 8'h02);
            wr(3'd5, 8'h28);
            wr(3'd3, 8'h23);
            wr(3'd2, 8'h59);
            wr(3'd1, 8'h59);
            commit_stage();
            tick1();
            dw = (dw == 7) ? 1 : dw + 1;
            if (y % 4 == 0) begin
                expect_reg("R4", "feb29 date", 3'd5, 8'h29);
                expect_reg("R4", "feb29 month", 3'd6, 8'h02);
                set_time(23, 59, 59);
                tick1();
                dw = (dw == 7) ? 1 : dw + 1;
            end
            expect_reg("R4", "mar1 date", 3'd5, 8'h01);
            expect_reg("R4", "mar1 month", 3'd6, 8'h03);
            expect_reg("R5", "dow", 3'd4, 8'h20 | 8'(cb << 4) | 8'(dw));
        end

        // R6 century held with cen_en clear
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h80);
        wr(3'd7, 8'h99);
        wr(3'd6, 8'h12);
        wr(3'd5, 8'h31);
        wr(3'd3, 8'h23);
        wr(3'd2, 8'h59);
        wr(3'd1, 8'h59);
        commit_stage();
        tick1();
        dw = (dw == 7) ? 1 : dw + 1;
        expect_reg("R4", "year wrap", 3'd7, 8'h00);
        expect_reg("R4", "month wrap", 3'd6, 8'h01);
        expect_reg("R6", "century kept", 3'd4, 8'(cb << 4) | 8'(dw));

        // R10 direct control bits, time digits ignored with W clear
        wr(3'd4, 8'h67);
        expect_reg("R10", "ftest+cen_en", 3'd4, 8'h60 | 8'(cb << 4) | 8'(dw));
        chk("R10", "ftest_en on", {7'b0, ftest_en}, 8'h01);

        // R7 stop
        wr(3'd1, 8'h80);
        expect_reg("R7", "stop set", 3'd1, 8'h80);
        chk("R10", "ftest_en stopped", {7'b0, ftest_en}, 8'h00);
        repeat (5) tick1();
        expect_reg("R7", "sec frozen", 3'd1, 8'h80);
        expect_reg("R7", "min frozen", 3'd2, 8'h00);
        wr(3'd1, 8'h00);
        tick1();
        expect_reg("R7", "sec resumes", 3'd1, 8'h01);

        // R8 writes ignored outside staging
        wr(3'd2, 8'h45);
        expect_reg("R8", "min unwritten", 3'd2, 8'h00);
        wr(3'd7, 8'h55);
        expect_reg("R8", "year unwritten", 3'd7, 8'h00);

        // R8 staging keeps counting, loads only staged bytes
        wr(3'd0, 8'h80);
        expect_reg("R8", "W readback", 3'd0, 8'h80);
        wr(3'd1, 8'h30);
        repeat (3) tick1();
        expect_reg("R8", "live during stage", 3'd1, 8'h04);
        wr(3'd0, 8'h00);
        @(negedge clk);
        expect_reg("R8", "sec loaded", 3'd1, 8'h30);
        expect_reg("R8", "min untouched", 3'd2, 8'h00);
        expect_reg("R8", "hour untouched", 3'd3, 8'h00);

        // R9 snapshot
        wr(3'd0, 8'h40);
        expect_reg("R9", "R readback", 3'd0, 8'h40);
        repeat (4) tick1();
        expect_reg("R9", "sec frozen read", 3'd1, 8'h30);
        wr(3'd0, 8'h00);
        expect_reg("R9", "sec live again", 3'd1, 8'h34);

        // R10 sign and calibration storage
        wr(3'd0, 8'h25);
        expect_reg("R10", "cal bits", 3'd0, 8'h25);
        wr(3'd0, 8'h00);

        // R11 battery-low flag
        batt_low = 1'b1;
        @(negedge clk);
        expect_reg("R11", "bl set", 3'd5, 8'h41);
        wr(3'd5, 8'h81);
        expect_reg("R11", "bl kept, batt_en set", 3'd5, 8'hC1);
        batt_low = 1'b0;
        @(negedge clk);
        wr(3'd5, 8'h40);
        expect_reg("R11", "bl write ignored", 3'd5, 8'h01);

        // R2 fixed-zero bits
        wr(3'd0, 8'h80);
        wr(3'd6, 8'hFF);
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'hFF);
        commit_stage();
        rd(3'd6, v);
        chk("R2", "month zero bits", v & 8'hE0, 8'h00);
        rd(3'd3, v);
        chk("R2", "hour zero bits", v & 8'hC0, 8'h00);
        rd(3'd2, v);
        chk("R2", "min zero bit", v & 8'h80, 8'h00);
        rd(3'd4, v);
        chk("R2", "cday zero bits", v & 8'h88, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule